// File: doc/BRIEF.md
# PLL Relock Guard and System Clock Select

This block decides when the system clock may be taken from the PLL. It watches a configuration write port that carries a crystal-select code, a PLL power-down bit and a use-PLL bit. Some writes force the PLL to relock: a crystal code that differs from the one held, or a move of the PLL out of power-down. On such a write the block loads a down counter that runs on the main oscillator clock. While that counter is nonzero the PLL is treated as not ready, and the clock select stays on the oscillator.

When the count expires, the ready flag rises. If the PLL has been chosen, the clock select moves to the PLL at the same moment. A raw lock status bit is set as well. Software clears that bit by writing one to it, and a mask bit lets it drive an interrupt line. Software can enable the PLL and choose it in a single write. The block then holds the oscillator until the relock time has passed.

Top module: `pll_relock_guard`

## Requirements
- R1: After reset the PLL is in power-down (`pwrdn_o`=1), `pll_ready_o`, `sel_pll_o`, `lock_raw_o`, `lock_mask_o` and `irq_o` are 0, and `xtal_o` equals XTAL_RST.
- R2: A configuration write whose crystal code differs from `xtal_o` starts a relock. `pll_ready_o` is 0 in the cycle after the write edge. It rises exactly RELOCK_COUNT clock edges after the write edge, if the PLL is not in power-down.
- R3: A configuration write with the same crystal code and no power-down-to-normal move leaves a running count and a present ready flag untouched.
- R4: A write that clears the power-down bit while `pwrdn_o`=1 starts a relock with the same timing as R2.
- R5: `sel_pll_o` is 1 only while `pll_ready_o` and the held use-PLL bit are both 1. A single write that enables and chooses the PLL keeps `sel_pll_o` at 0 for RELOCK_COUNT edges, and then sets it.
- R6: A relock event during a running count reloads the counter to RELOCK_COUNT. Ready then comes RELOCK_COUNT edges after the latest event.
- R7: A write that sets the power-down bit clears `pll_ready_o` and `sel_pll_o` in the same cycle in which `pwrdn_o` becomes 1. Ready stays 0 for as long as power-down is held.
- R8: `lock_raw_o` is set at the same edge at which `pll_ready_o` rises.
- R9: A write to the clear port with data bit 1 clears `lock_raw_o` at the next edge. If that write falls on the edge of a new lock event, the bit stays 1.
- R10: `irq_o` is 1 exactly when `lock_raw_o` and `lock_mask_o` are both 1. The mask is loaded from the mask write port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_xtal | input | XTAL_W | Crystal-select code written |
| cfg_wr_pwrdn | input | 1 | PLL power-down bit written |
| cfg_wr_use_pll | input | 1 | Use-PLL select bit written |
| mask_wr_en | input | 1 | Lock interrupt mask write strobe |
| mask_wr_data | input | 1 | Mask value written |
| clr_wr_en | input | 1 | Lock status clear write strobe |
| clr_wr_data | input | 1 | Clear data; 1 clears the raw status |
| xtal_o | output | XTAL_W | Crystal code now held |
| pwrdn_o | output | 1 | PLL power-down state held |
| pll_ready_o | output | 1 | Relock time met, PLL usable |
| sel_pll_o | output | 1 | Clock select: 1 = PLL, 0 = oscillator |
| lock_raw_o | output | 1 | Raw lock status |
| lock_mask_o | output | 1 | Lock interrupt mask |
| irq_o | output | 1 | Masked lock interrupt |

## Verification
The bench builds the block with XTAL_W=3 and RELOCK_COUNT=6. The short count lets every relock run to expiry many times, and it lets a second event land at each offset of a running countdown. The 3-bit crystal code makes a full sweep of all 64 old-to-new code pairs affordable, so each changed code and each repeated code is tried from a ready state.

// File: rtl/pll_guard_pkg.sv
package pll_guard_pkg;

  typedef struct packed {
    logic pwrdn;
    logic use_pll;
  } pll_mode_t;

  localparam pll_mode_t MODE_RST = '{pwrdn: 1'b1, use_pll: 1'b0};

endpackage

// File: rtl/pll_cfg_reg.sv
module pll_cfg_reg
  import pll_guard_pkg::*;
#(
  parameter int unsigned XTAL_W   = 5,
  parameter logic [XTAL_W-1:0] XTAL_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [XTAL_W-1:0] wr_xtal,
  input  logic              wr_pwrdn,
  input  logic              wr_use_pll,
  output logic [XTAL_W-1:0] xtal_q,
  output pll_mode_t         mode_q,
  output logic              relock_evt,
  output logic              pwrdn_req
);

  logic [XTAL_W-1:0] xtal_d;
  pll_mode_t         mode_d;
  logic              xtal_changed;
  logic              wake;

  always_comb begin
    xtal_changed = (wr_xtal != xtal_q);
    wake         = mode_q.pwrdn & ~wr_pwrdn;
    relock_evt   = wr_en & (xtal_changed | wake);
    pwrdn_req    = wr_en & wr_pwrdn;
    xtal_d       = xtal_q;
    mode_d       = mode_q;
    if (wr_en) begin
      xtal_d         = wr_xtal;
      mode_d.pwrdn   = wr_pwrdn;
      mode_d.use_pll = wr_use_pll;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xtal_q <= XTAL_RST;
      mode_q <= MODE_RST;
    end else begin
      xtal_q <= xtal_d;
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/pll_relock_timer.sv
module pll_relock_timer #(
  parameter int unsigned RELOCK_COUNT = 32'h1200,
  localparam int unsigned CNT_W = $clog2(RELOCK_COUNT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic relock_evt,
  input  logic pwrdn_req,
  input  logic pwrdn_q,
  output logic ready_q,
  output logic lock_evt
);

  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(RELOCK_COUNT);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ready_d;
  logic             cnt_en;

  always_comb begin
    cnt_d    = cnt_q;
    ready_d  = ready_q;
    lock_evt = 1'b0;
    cnt_en   = (cnt_q != '0);
    if (relock_evt) begin
      cnt_d   = RELOAD;
      ready_d = 1'b0;
    end else if (cnt_en) begin
      cnt_d = cnt_q - LAST;
      if (cnt_q == LAST && !pwrdn_q && !pwrdn_req) begin
        ready_d  = 1'b1;
        lock_evt = 1'b1;
      end
    end
    if (pwrdn_req) begin
      ready_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ready_q <= ready_d;
    end
  end

endmodule

// File: rtl/pll_lock_status.sv
module pll_lock_status (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_evt,
  input  logic mask_wr_en,
  input  logic mask_wr_data,
  input  logic clr_wr_en,
  input  logic clr_wr_data,
  output logic raw_q,
  output logic mask_q,
  output logic irq
);

  logic raw_d, mask_d, clr;

  always_comb begin
    clr    = clr_wr_en & clr_wr_data;
    raw_d  = lock_evt | (raw_q & ~clr);
    mask_d = mask_wr_en ? mask_wr_data : mask_q;
    irq    = raw_q & mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end

endmodule

// File: rtl/pll_relock_guard.sv
module pll_relock_guard
  import pll_guard_pkg::*;
#(
  parameter int unsigned XTAL_W       = 5,
  parameter logic [XTAL_W-1:0] XTAL_RST = '0,
  parameter int unsigned RELOCK_COUNT = 32'h1200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [XTAL_W-1:0] cfg_wr_xtal,
  input  logic              cfg_wr_pwrdn,
  input  logic              cfg_wr_use_pll,
  input  logic              mask_wr_en,
  input  logic              mask_wr_data,
  input  logic              clr_wr_en,
  input  logic              clr_wr_data,
  output logic [XTAL_W-1:0] xtal_o,
  output logic              pwrdn_o,
  output logic              pll_ready_o,
  output logic              sel_pll_o,
  output logic              lock_raw_o,
  output logic              lock_mask_o,
  output logic              irq_o
);

  pll_mode_t mode_q;
  logic      relock_evt, pwrdn_req, ready_q, lock_evt;

  pll_cfg_reg #(.XTAL_W(XTAL_W), .XTAL_RST(XTAL_RST)) cfg_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr_en),
    .wr_xtal    (cfg_wr_xtal),
    .wr_pwrdn   (cfg_wr_pwrdn),
    .wr_use_pll (cfg_wr_use_pll),
    .xtal_q     (xtal_o),
    .mode_q     (mode_q),
    .relock_evt (relock_evt),
    .pwrdn_req  (pwrdn_req)
  );

  pll_relock_timer #(.RELOCK_COUNT(RELOCK_COUNT)) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .relock_evt (relock_evt),
    .pwrdn_req  (pwrdn_req),
    .pwrdn_q    (mode_q.pwrdn),
    .ready_q    (ready_q),
    .lock_evt   (lock_evt)
  );

  pll_lock_status status_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .lock_evt     (lock_evt),
    .mask_wr_en   (mask_wr_en),
    .mask_wr_data (mask_wr_data),
    .clr_wr_en    (clr_wr_en),
    .clr_wr_data  (clr_wr_data),
    .raw_q        (lock_raw_o),
    .mask_q       (lock_mask_o),
    .irq          (irq_o)
  );

  assign pwrdn_o     = mode_q.pwrdn;
  assign pll_ready_o = ready_q;
  assign sel_pll_o   = mode_q.use_pll & ready_q;

endmodule

// File: rtl/pll_relock_guard_chk.sv
module pll_relock_guard_chk #(
  parameter int unsigned XTAL_W       = 5,
  parameter int unsigned RELOCK_COUNT = 32'h1200,
  localparam int unsigned SW = $clog2(RELOCK_COUNT + 1) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [XTAL_W-1:0] cfg_wr_xtal,
  input logic              cfg_wr_pwrdn,
  input logic              clr_wr_en,
  input logic              clr_wr_data,
  input logic [XTAL_W-1:0] xtal_o,
  input logic              pwrdn_o,
  input logic              pll_ready_o,
  input logic              sel_pll_o,
  input logic              lock_raw_o,
  input logic              irq_o
);

  localparam logic [SW-1:0] EXPIRE = SW'(RELOCK_COUNT + 1);

  logic          ev;
  logic [SW-1:0] since_q;

  assign ev = cfg_wr_en && ((cfg_wr_xtal != xtal_o) || (pwrdn_o && !cfg_wr_pwrdn));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q <= '0;
    end else if (ev) begin
      since_q <= SW'(1);
    end else if (since_q != '0 && since_q != '1) begin
      since_q <= since_q + SW'(1);
    end
  end

  // R2
  relock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> !pll_ready_o);

  // R6
  ready_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_ready_o) |-> (since_q == EXPIRE));

  // R3
  same_xtal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_xtal == xtal_o && !cfg_wr_pwrdn && pll_ready_o) |=> pll_ready_o);

  // R5
  sel_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_pll_o |-> pll_ready_o);

  // R7
  pwrdn_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn_o |-> (!pll_ready_o && !sel_pll_o));

  // R8
  raw_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_ready_o) |-> lock_raw_o);

  // R9
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr_en && clr_wr_data && pll_ready_o && !ev) |=> !lock_raw_o);

  // R10
  irq_needs_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> lock_raw_o);

endmodule

bind pll_relock_guard pll_relock_guard_chk #(
  .XTAL_W(XTAL_W), .RELOCK_COUNT(RELOCK_COUNT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_xtal(cfg_wr_xtal),
  .cfg_wr_pwrdn(cfg_wr_pwrdn), .clr_wr_en(clr_wr_en), .clr_wr_data(clr_wr_data),
  .xtal_o(xtal_o), .pwrdn_o(pwrdn_o), .pll_ready_o(pll_ready_o),
  .sel_pll_o(sel_pll_o), .lock_raw_o(lock_raw_o), .irq_o(irq_o)
);

// File: tb/pll_relock_guard_tb_top.sv
module pll_relock_guard_tb_top;

  localparam int unsigned XW = 3;
  localparam int unsigned N  = 6;
  localparam logic [XW-1:0] XR = 3'd2;

  logic          clk, rst_n;
  logic          cfg_wr_en, cfg_wr_pwrdn, cfg_wr_use_pll;
  logic [XW-1:0] cfg_wr_xtal;
  logic          mask_wr_en, mask_wr_data, clr_wr_en, clr_wr_data;
  logic [XW-1:0] xtal_o;
  logic          pwrdn_o, pll_ready_o, sel_pll_o, lock_raw_o, lock_mask_o, irq_o;

  int n_vec, n_bad;
  bit done;

  pll_relock_guard #(.XTAL_W(XW), .XTAL_RST(XR), .RELOCK_COUNT(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_xtal(cfg_wr_xtal),
    .cfg_wr_pwrdn(cfg_wr_pwrdn), .cfg_wr_use_pll(cfg_wr_use_pll),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .clr_wr_en(clr_wr_en), .clr_wr_data(clr_wr_data),
    .xtal_o(xtal_o), .pwrdn_o(pwrdn_o), .pll_ready_o(pll_ready_o),
    .sel_pll_o(sel_pll_o), .lock_raw_o(lock_raw_o), .lock_mask_o(lock_mask_o),
    .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cfg_wr(input logic [XW-1:0] x, input logic pd, input logic up);
    cfg_wr_en = 1'b1; cfg_wr_xtal = x; cfg_wr_pwrdn = pd; cfg_wr_use_pll = up;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic clr_raw();
    clr_wr_en = 1'b1; clr_wr_data = 1'b1;
    @(negedge clk);
    clr_wr_en = 1'b0;
  endtask

  task automatic set_mask(input logic m);
    mask_wr_en = 1'b1; mask_wr_data = m;
    @(negedge clk);
    mask_wr_en = 1'b0;
  endtask

  // Called right after the event write: ready at edge k+N.
  task automatic expect_relock(input string req);
    check(req, int'(pll_ready_o), 0);
    repeat (N - 1) @(negedge clk);
    check(req, int'(pll_ready_o), 0);
    @(negedge clk);
    check(req, int'(pll_ready_o), 1);
    check("R8", int'(lock_raw_o), 1);
  endtask

  task automatic go_ready(input logic [XW-1:0] x, input logic up);
    cfg_wr(x, 1'b1, 1'b0);
    cfg_wr(x, 1'b0, up);
    repeat (N) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; cfg_wr_en = 0; cfg_wr_xtal = '0; cfg_wr_pwrdn = 0; cfg_wr_use_pll = 0;
    mask_wr_en = 0; mask_wr_data = 0; clr_wr_en = 0; clr_wr_data = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", int'(pwrdn_o), 1);
    check("R1", int'(pll_ready_o), 0);
    check("R1", int'(sel_pll_o), 0);
    check("R1", int'(lock_raw_o), 0);
    check("R1", int'(irq_o), 0);
    check("R1", int'(xtal_o), int'(XR));
    check("R1", int'(lock_mask_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 and R5: enable and select in one write
    cfg_wr(XR, 1'b0, 1'b1);
    check("R5", int'(sel_pll_o), 0);
    repeat (N - 1) @(negedge clk);
    check("R5", int'(sel_pll_o), 0);
    check("R4", int'(pll_ready_o), 0);
    @(negedge clk);
    check("R5", int'(sel_pll_o), 1);
    check("R4", int'(pll_ready_o), 1);

    // R7 power-down drops ready and select together
    cfg_wr(XR, 1'b1, 1'b1);
    check("R7", int'(pwrdn_o), 1);
    check("R7", int'(pll_ready_o), 0);
    check("R7", int'(sel_pll_o), 0);
    cfg_wr(3'd5, 1'b1, 1'b1);
    repeat (N + 2) @(negedge clk);
    check("R7", int'(pll_ready_o), 0);

    // R7 power-down in the middle of a count
    cfg_wr(3'd5, 1'b0, 1'b0);
    @(negedge clk);
    cfg_wr(3'd5, 1'b1, 1'b0);
    repeat (N + 2) @(negedge clk);
    check("R7", int'(pll_ready_o), 0);

    // R2 / R3 sweep over every old/new code pair
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        go_ready(XW'(a), 1'b0);
        clr_raw();
        check("R9", int'(lock_raw_o), 0);
        cfg_wr(XW'(b), 1'b0, 1'b0);
        if (a != b) begin
          expect_relock("R2");
        end else begin
          repeat (N + 1) begin
            check("R3", int'(pll_ready_o), 1);
            @(negedge clk);
          end
          check("R3", int'(lock_raw_o), 0);
        end
      end
    end

    // R6 second event at every offset of a running count
    for (int j = 1; j < N; j++) begin
      cfg_wr(3'd0, 1'b1, 1'b0);
      cfg_wr(3'd0, 1'b0, 1'b0);
      repeat (j - 1) @(negedge clk);
      check("R6", int'(pll_ready_o), 0);
      cfg_wr(3'd1, 1'b0, 1'b0);
      expect_relock("R6");
    end

    // R3 same code during a running count does not restart it
    cfg_wr(3'd4, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    cfg_wr(3'd4, 1'b0, 1'b0);
    repeat (N - 4) @(negedge clk);
    check("R3", int'(pll_ready_o), 0);
    @(negedge clk);
    check("R3", int'(pll_ready_o), 1);

    // R9 clear on the same edge as a lock event keeps the bit
    clr_raw();
    cfg_wr(3'd6, 1'b0, 1'b0);
    repeat (N - 1) @(negedge clk);
    clr_raw();
    check("R9", int'(lock_raw_o), 1);
    clr_raw();
    check("R9", int'(lock_raw_o), 0);
    clr_wr_en = 1'b1; clr_wr_data = 1'b0;
    cfg_wr(3'd7, 1'b0, 1'b0);
    clr_wr_en = 1'b0;
    repeat (N) @(negedge clk);
    check("R9", int'(lock_raw_o), 1);

    // R10 mask and raw combinations
    for (int m = 0; m < 2; m++) begin
      for (int r = 0; r < 2; r++) begin
        set_mask(logic'(m));
        if (r == 0) clr_raw();
        else begin
          cfg_wr(3'd0, 1'b0, 1'b0);
          cfg_wr(3'd3, 1'b0, 1'b0);
          repeat (N) @(negedge clk);
        end
        check("R10", int'(lock_mask_o), m);
        check("R10", int'(irq_o), m & r);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule